// File: doc/BRIEF.md
# Dual-Synthesizer Serial Programming Port

This block receives configuration words for a pair of frequency synthesizers over a three-wire serial link: a serial clock, a data line and a load strobe. Bits are captured most significant first into a 20-bit shift register, one bit per rising serial-clock edge. When the load strobe rises, the two bits shifted in last pick one of four holding registers: a reference-divider word or a feedback-divider word, for either synthesizer channel. The whole 20-bit word is copied into that register.

The three serial lines are asynchronous to the system clock. They pass through a synchronizer of configurable depth and are then edge-detected in the system clock domain. The held words are split into output fields:
- each reference register gives a 13-bit reference divider, phase-detector polarity, charge-pump current level, charge-pump tri-state and a 2-bit output select;
- each feedback register gives a 16-bit feedback divider, a prescaler select and a power-down flag.

Power-down flags are only passed on to the outputs. They never stop the port from accepting words.

Top module: `synth_prog_if`

## Requirements
- R1: After reset every output field of all four holding registers reads zero: negative polarity, low pump current, pump active, output select 0, 64/65 prescaler, powered up.
- R2: The word is formed from the last 20 bits shifted in, MSB first. Bit 20 is the first of these bits and bit 1 is the last. Any earlier bits are discarded.
- R3: On a load, exactly one holding register takes the word, selected by bit 1 (C1) and bit 2 (C2):
  - C1=0, C2=0: channel-2 reference register.
  - C1=0, C2=1: channel-1 reference register.
  - C1=1, C2=0: channel-2 feedback register.
  - C1=1, C2=1: channel-1 feedback register.
- R4: A reference word maps bits as follows:
  - bits 3..15 to the reference divider (bit 3 is the LSB);
  - bit 16 to polarity;
  - bit 17 to the pump current level;
  - bit 18 to pump tri-state;
  - bits 19..20 to the output select (bit 19 is the LSB).
- R5: A feedback word maps bits 3..18 to the feedback divider (bit 3 is the LSB), bit 19 to the prescaler select (1 selects 128/129) and bit 20 to power-down.
- R6: Holding registers change only on a rising edge of the load strobe. Serial clocks while the strobe stays high still shift, but nothing is loaded until the strobe falls and rises again.
- R7: Only rising serial-clock edges shift. Data-line changes while the serial clock is steady have no effect on the next loaded word.
- R8: A set power-down flag on either or both channels does not stop shifting or loading.
- R9: Output port index 0 carries channel 1 and index 1 carries channel 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_load_i | input | 1 | Load strobe, rising edge loads |
| ref_div_o | output | 2x13 | Reference divider per channel |
| pd_pol_o | output | 2 | Phase-detector polarity per channel |
| cp_hi_o | output | 2 | Charge-pump high current per channel |
| cp_tri_o | output | 2 | Charge-pump tri-state per channel |
| out_sel_o | output | 2x2 | Output select per channel |
| fb_div_o | output | 2x16 | Feedback divider per channel |
| pre_sel_o | output | 2 | Prescaler select per channel |
| pwdn_o | output | 2 | Power-down per channel |

## Verification
The bench writes each of the four addresses with distinct patterns and checks that the other three registers keep their contents. A swapped C1/C2 decode or an inverted channel index would show up as fields appearing on the wrong channel. Field patterns are placed at the bit boundaries, so an off-by-one slice would shift a divider or move a mode bit into a neighbouring field. A 24-bit burst exposes a design that keeps stale leading bits. Clocking a new word while the strobe stays high catches a design that loads on level rather than edge, and wiggling the data line with no clock catches one that samples data without a clock edge. Both power-down flags are set and writes are then repeated, to catch a design that lets power-down freeze the port.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W    = 20;
  localparam int ADDR_W    = 2;
  localparam int HOLD_W    = WORD_W - ADDR_W;
  localparam int NUM_CH    = 2;
  localparam int REF_DIV_W = 13;
  localparam int FB_DIV_W  = 16;
  localparam int OSEL_W    = 2;

  typedef enum logic [1:0] {
    SEL_REF_CH2 = 2'b00,
    SEL_REF_CH1 = 2'b10,
    SEL_FB_CH2  = 2'b01,
    SEL_FB_CH1  = 2'b11
  } sel_e;  // {C2,C1}
endpackage

// File: rtl/sync_bus.sv
module sync_bus #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= '0;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ser_shift.sv
module ser_shift
  import synth_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              din_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], din_i};
  end

  assign word_o = sr_q;

  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q)); // R7
  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (sr_q[0] == $past(din_i)) && (sr_q[WORD_W-1:1] == $past(sr_q[WORD_W-2:0]))); // R2
endmodule

// File: rtl/hold_bank.sv
module hold_bank
  import synth_prog_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              load_i,
  input  logic [WORD_W-1:0]                 word_i,
  output logic [NUM_CH-1:0][REF_DIV_W-1:0]  ref_div_o,
  output logic [NUM_CH-1:0]                 pd_pol_o,
  output logic [NUM_CH-1:0]                 cp_hi_o,
  output logic [NUM_CH-1:0]                 cp_tri_o,
  output logic [NUM_CH-1:0][OSEL_W-1:0]     out_sel_o,
  output logic [NUM_CH-1:0][FB_DIV_W-1:0]   fb_div_o,
  output logic [NUM_CH-1:0]                 pre_sel_o,
  output logic [NUM_CH-1:0]                 pwdn_o
);
  logic [NUM_CH-1:0][HOLD_W-1:0] ref_q, fb_q;
  logic [NUM_CH-1:0]             ref_we, fb_we;
  sel_e                          sel;
  logic                          ch_idx;

  assign sel    = sel_e'({word_i[1], word_i[0]});
  assign ch_idx = ~word_i[1];  // C2=1 -> channel 1 at index 0

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign ref_we[ch] = load_i && !word_i[0] && (ch_idx == 1'(ch));
    assign fb_we[ch]  = load_i &&  word_i[0] && (ch_idx == 1'(ch));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ref_q[ch] <= '0;
        fb_q[ch]  <= '0;
      end else begin
        if (ref_we[ch]) ref_q[ch] <= word_i[WORD_W-1:ADDR_W];
        if (fb_we[ch])  fb_q[ch]  <= word_i[WORD_W-1:ADDR_W];
      end
    end

    assign ref_div_o[ch] = ref_q[ch][REF_DIV_W-1:0];
    assign pd_pol_o[ch]  = ref_q[ch][REF_DIV_W];
    assign cp_hi_o[ch]   = ref_q[ch][REF_DIV_W+1];
    assign cp_tri_o[ch]  = ref_q[ch][REF_DIV_W+2];
    assign out_sel_o[ch] = ref_q[ch][REF_DIV_W+3 +: OSEL_W];
    assign fb_div_o[ch]  = fb_q[ch][FB_DIV_W-1:0];
    assign pre_sel_o[ch] = fb_q[ch][FB_DIV_W];
    assign pwdn_o[ch]    = fb_q[ch][FB_DIV_W+1];
  end

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ref_we, fb_we})); // R3
  AST_LOAD_HITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> $countones({ref_we, fb_we}) == 1); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ref_q) && $stable(fb_q)); // R6
  AST_CH1_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && sel == SEL_REF_CH1) |=> ref_q[0] == $past(word_i[WORD_W-1:ADDR_W])); // R9
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              ser_clk_i,
  input  logic                              ser_data_i,
  input  logic                              ser_load_i,
  output logic [NUM_CH-1:0][REF_DIV_W-1:0]  ref_div_o,
  output logic [NUM_CH-1:0]                 pd_pol_o,
  output logic [NUM_CH-1:0]                 cp_hi_o,
  output logic [NUM_CH-1:0]                 cp_tri_o,
  output logic [NUM_CH-1:0][OSEL_W-1:0]     out_sel_o,
  output logic [NUM_CH-1:0][FB_DIV_W-1:0]   fb_div_o,
  output logic [NUM_CH-1:0]                 pre_sel_o,
  output logic [NUM_CH-1:0]                 pwdn_o
);
  logic [2:0]        sync_q;
  logic              sclk_s, sdat_s, sld_s;
  logic              sclk_d, sld_d;
  logic              shift_en, load_en;
  logic [WORD_W-1:0] word;

  sync_bus #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_load_i, ser_data_i, ser_clk_i}),
    .q_o   (sync_q)
  );

  assign {sld_s, sdat_s, sclk_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      sld_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      sld_d  <= sld_s;
    end
  end

  assign shift_en = sclk_s & ~sclk_d;
  assign load_en  = sld_s & ~sld_d;

  ser_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .din_i  (sdat_s),
    .word_o (word)
  );

  hold_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_en),
    .word_i   (word),
    .ref_div_o(ref_div_o),
    .pd_pol_o (pd_pol_o),
    .cp_hi_o  (cp_hi_o),
    .cp_tri_o (cp_tri_o),
    .out_sel_o(out_sel_o),
    .fb_div_o (fb_div_o),
    .pre_sel_o(pre_sel_o),
    .pwdn_o   (pwdn_o)
  );

  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> !load_en); // R6
  AST_SHIFT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> !shift_en); // R7
endmodule

// File: tb/synth_prog_if_test.sv
module synth_prog_if_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sld = 1'b0;
  logic [1:0][12:0] ref_div;
  logic [1:0]       pd_pol, cp_hi, cp_tri, pre_sel, pwdn;
  logic [1:0][1:0]  out_sel;
  logic [1:0][15:0] fb_div;

  int total = 0, bad = 0;
  bit done = 0;

  logic [19:0] e_ref [2];
  logic [19:0] e_fb  [2];

  always #2.5 clk = ~clk;

  synth_prog_if uut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdat), .ser_load_i(sld),
    .ref_div_o(ref_div), .pd_pol_o(pd_pol), .cp_hi_o(cp_hi), .cp_tri_o(cp_tri),
    .out_sel_o(out_sel), .fb_div_o(fb_div), .pre_sel_o(pre_sel), .pwdn_o(pwdn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = v[i];
      wait_clk(3);
      sclk = 1'b1;
      wait_clk(3);
      sclk = 1'b0;
      wait_clk(2);
    end
  endtask

  task automatic pulse_load();
    sld = 1'b1;
    wait_clk(6);
    sld = 1'b0;
    wait_clk(6);
  endtask

  // model: C1 = bit0, C2 = bit1; index 0 = channel 1
  task automatic model_load(logic [19:0] w);
    int ch = w[1] ? 0 : 1;
    if (w[0]) e_fb[ch] = w;
    else e_ref[ch] = w;
  endtask

  task automatic write_word(logic [19:0] w);
    send_bits({12'h0, w}, 20);
    pulse_load();
    model_load(w);
  endtask

  task automatic check_all(string req);
    for (int ch = 0; ch < 2; ch++) begin
      chk(req, ref_div[ch],        32'(e_ref[ch][14:2]));
      chk(req, pd_pol[ch],         32'(e_ref[ch][15]));
      chk(req, cp_hi[ch],          32'(e_ref[ch][16]));
      chk(req, cp_tri[ch],         32'(e_ref[ch][17]));
      chk(req, out_sel[ch],        32'(e_ref[ch][19:18]));
      chk(req, fb_div[ch],         32'(e_fb[ch][17:2]));
      chk(req, pre_sel[ch],        32'(e_fb[ch][18]));
      chk(req, pwdn[ch],           32'(e_fb[ch][19]));
    end
  endtask

  task automatic t_reset();
    for (int ch = 0; ch < 2; ch++) begin e_ref[ch] = '0; e_fb[ch] = '0; end
    check_all("R1");
  endtask

  task automatic t_decode();
    write_word({13'h1ABC, 1'b1, 1'b0, 1'b1, 2'b10, 2'b10});  // ch1 ref
    check_all("R3 R9 ch1 ref");
    write_word({2'b01, 1'b0, 1'b1, 1'b0, 13'h0555, 2'b00});  // ch2 ref
    check_all("R3 R9 ch2 ref");
    write_word({1'b0, 1'b1, 16'hBEEF, 2'b11});               // ch1 fb
    check_all("R3 R5 ch1 fb");
    write_word({1'b1, 1'b0, 16'h1234, 2'b01});               // ch2 fb
    check_all("R3 R5 ch2 fb");
  endtask

  task automatic t_fields();
    write_word({2'b01, 1'b0, 1'b0, 1'b1, 13'h1000, 2'b10});
    check_all("R4 pol bit16 div msb");
    write_word({2'b10, 1'b1, 1'b1, 1'b0, 13'h0001, 2'b10});
    check_all("R4 osel tri cp");
    write_word({1'b0, 1'b1, 16'h8001, 2'b01});
    check_all("R5 prescaler edges");
  endtask

  task automatic t_long();
    logic [31:0] v = 32'h00A_5F3C2;
    v[23:20] = 4'hF;
    send_bits(v, 24);
    pulse_load();
    model_load(v[19:0]);
    check_all("R2 long burst");
  endtask

  task automatic t_load_edge();
    write_word({13'h0AAA, 5'b00000, 2'b10});
    sld = 1'b1;
    wait_clk(6);
    send_bits({12'h0, 13'h1555, 5'b11111, 2'b10}, 20);
    wait_clk(6);
    check_all("R6 strobe high no load");
    sld = 1'b0;
    wait_clk(6);
    pulse_load();
    model_load({13'h1555, 5'b11111, 2'b10});
    check_all("R6 next rise loads");
  endtask

  task automatic t_no_clock();
    logic [19:0] w = {2'b11, 1'b1, 1'b0, 1'b1, 13'h0F0F, 2'b00};
    send_bits({12'h0, w}, 20);
    for (int i = 0; i < 6; i++) begin sdat = ~sdat; wait_clk(4); end
    pulse_load();
    model_load(w);
    check_all("R7 data wiggle ignored");
  endtask

  task automatic t_pwdn();
    write_word({1'b1, 1'b0, 16'h0F0F, 2'b11});
    write_word({1'b1, 1'b1, 16'h7777, 2'b01});
    check_all("R8 both powered down");
    write_word({2'b11, 3'b111, 13'h1FFF, 2'b10});
    write_word({1'b1, 1'b1, 16'hFFFF, 2'b11});
    check_all("R8 writes while down");
  endtask

  initial begin
    wait_clk(4);
    t_reset();
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_decode();
    t_fields();
    t_long();
    t_load_edge();
    t_no_clock();
    t_pwdn();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule